// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache Controller

This block sits between a processor's load/store port and a word-addressed main memory. It keeps 128 sets of two ways, each way holding one 32-byte line (eight 32-bit words) together with a tag and a valid bit. Loads that find their line resident answer in the cycle after they are accepted. Loads that do not find it fetch the whole line from memory as a burst, place it in the least-recently-used way of its set, and then answer.

Stores are always sent to memory, one word at a time, whether or not their line is resident. A store to a resident line also updates the cached copy, so the cache never holds data that memory lacks. A store to a line that is not resident leaves the cache untouched. A load that follows it to the same line therefore still goes to memory.

The processor side uses a valid/ready request handshake with a separate read-data response strobe. The memory side has a one-cycle line-read request answered by eight data beats, and a word-write request held until memory acknowledges it.

Top module: `wtc_cache_top`

## Requirements
- R1: After reset, `req_ready` is 1 while `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0, and every way is invalid, so the first load to any line misses.
- R2: A request address is split into byte offset [1:0] (requests are word aligned, so these bits are 0), word-in-line [4:2], set index [11:5] and tag [31:12]. Two addresses that differ only in bits [4:2] share a line.
- R3: A load that hits raises `rsp_valid` with the addressed word in the cycle after acceptance and issues no memory read.
- R4: A load that misses raises `mem_rd_req` for one cycle with `mem_rd_addr` equal to the line's first word address (request address bits [31:5] followed by three zero bits). It then takes eight `mem_rvalid` beats carrying words 0 to 7 in order and answers with the addressed word in the cycle after the last beat. Later loads to that line hit.
- R5: Every accepted store holds `mem_wr_req` high, with `mem_wr_addr` equal to request address bits [31:2] and `mem_wr_data` equal to the store data, until `mem_wr_ack`. `req_ready` stays low until the acknowledge. A store produces no `rsp_valid`.
- R6: A store that misses issues no memory read and allocates nothing. A following load to that line misses and returns the stored data.
- R7: A store that hits updates the cached word, so a following load to that word hits and returns the new data.
- R8: Two lines with the same set index and different tags can both be resident, so alternating loads to them hit once both are filled.
- R9: One recency bit per set names the way to replace. It points away from the way touched by each load hit and each fill, and store hits leave it unchanged.
- R10: On a miss, an invalid way of the set is filled before any valid way is replaced.
- R11: `req_ready` is 0 from the cycle after a load miss is accepted until the miss is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rsp_valid | output | 1 | Load data strobe |
| rsp_rdata | output | 32 | Load data |
| mem_rd_req | output | 1 | One-cycle line read request |
| mem_rd_addr | output | 30 | Word address of the line's first word |
| mem_rvalid | input | 1 | Line read data beat |
| mem_rdata | input | 32 | Line read data |
| mem_wr_req | output | 1 | Word write request, held until acknowledged |
| mem_wr_addr | output | 30 | Word write address |
| mem_wr_data | output | 32 | Word write data |
| mem_wr_ack | input | 1 | Write acknowledge |

## Verification
On every cycle, the assertions check the immediate consequences of an accepted request. A hit answers next cycle without a memory read. A miss raises the line request and drops ready. A store raises a write request that stays stable until acknowledged. No set ever matches in both ways. Whether the data returned is correct cannot be shown by a property. Neither can the choice of victim way, or the fact that a store miss leaves nothing behind. The bench scenarios show these: same-set conflicts across three tags, a store hit followed by a reload, and a cold store followed by loads to its line. Each is compared against the bench's own memory image and its count of line reads.

// File: rtl/cache_pkg.sv
package cache_pkg;
    parameter int ADDR_W     = 32;
    parameter int DATA_W     = 32;
    parameter int NUM_SETS   = 128;
    parameter int NUM_WAYS   = 2;
    parameter int LINE_BYTES = 32;

    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int WORDS    = LINE_BYTES / (DATA_W / 8);
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int IDX_W    = $clog2(NUM_SETS);
    localparam int TAG_W    = ADDR_W - IDX_W - WSEL_W - BYTE_W;
    localparam int WADDR_W  = ADDR_W - BYTE_W;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int DADDR_W  = IDX_W + WSEL_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] word;
        logic [BYTE_W-1:0] boff;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_DATA,
        ST_WRITE
    } state_e;

    function automatic logic [WADDR_W-1:0] line_base(addr_t a);
        return {a.tag, a.idx, {WSEL_W{1'b0}}};
    endfunction

    function automatic logic [WADDR_W-1:0] word_addr(addr_t a);
        return {a.tag, a.idx, a.word};
    endfunction
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
    import cache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     lk_idx,
    input  logic [TAG_W-1:0]     lk_tag,
    output logic [NUM_WAYS-1:0]  way_hit,
    output logic [NUM_WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0]     lru_way,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [WAY_W-1:0]     fill_way,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic                 touch_en,
    input  logic [IDX_W-1:0]     touch_idx,
    input  logic [WAY_W-1:0]     touch_way
);
    logic [NUM_SETS-1:0] lru_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0]    tags_q [NUM_SETS];
        logic [NUM_SETS-1:0] vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (fill_en && fill_way == WAY_W'(w)) begin
                vld_q[fill_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_W'(w)) begin
                tags_q[fill_idx] <= fill_tag;
            end
        end

        assign way_valid[w] = vld_q[lk_idx];
        assign way_hit[w]   = vld_q[lk_idx] && (tags_q[lk_idx] == lk_tag);
    end

    // Recency: one bit per set naming the way to evict next.
    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_idx] <= ~touch_way;
        end
    end

    assign lru_way = lru_q[lk_idx];

    p_hit_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store
    import cache_pkg::*;
(
    input  logic                             clk,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic [WSEL_W-1:0]                rd_word,
    output logic [NUM_WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                             wr_en,
    input  logic [WAY_W-1:0]                 wr_way,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [WSEL_W-1:0]                wr_word,
    input  logic [DATA_W-1:0]                wr_data
);
    localparam int DEPTH = NUM_SETS * WORDS;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(w)) begin
                mem_q[{wr_idx, wr_word}] <= wr_data;
            end
        end

        assign rd_data[w] = mem_q[DADDR_W'({rd_idx, rd_word})];
    end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import cache_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    input  logic                             req_write,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [DATA_W-1:0]                req_wdata,
    output logic                             req_ready,
    output logic                             rsp_valid,
    output logic [DATA_W-1:0]                rsp_rdata,
    output logic                             mem_rd_req,
    output logic [WADDR_W-1:0]               mem_rd_addr,
    input  logic                             mem_rvalid,
    input  logic [DATA_W-1:0]                mem_rdata,
    output logic                             mem_wr_req,
    output logic [WADDR_W-1:0]               mem_wr_addr,
    output logic [DATA_W-1:0]                mem_wr_data,
    input  logic                             mem_wr_ack,
    input  logic [NUM_WAYS-1:0]              way_hit,
    input  logic [NUM_WAYS-1:0]              way_valid,
    input  logic [WAY_W-1:0]                 lru_way,
    input  logic [NUM_WAYS-1:0][DATA_W-1:0]  way_rdata,
    output logic                             fill_en,
    output logic                             touch_en,
    output logic [IDX_W-1:0]                 touch_idx,
    output logic [WAY_W-1:0]                 touch_way,
    output logic                             dwr_en,
    output logic [WAY_W-1:0]                 dwr_way,
    output logic [IDX_W-1:0]                 dwr_idx,
    output logic [WSEL_W-1:0]                dwr_word,
    output logic [DATA_W-1:0]                dwr_data,
    output logic [IDX_W-1:0]                 sav_idx,
    output logic [TAG_W-1:0]                 sav_tag,
    output logic [WAY_W-1:0]                 sav_way
);
    state_e              state_q;
    addr_t               sav_q;
    logic [DATA_W-1:0]   wdat_q;
    logic [WAY_W-1:0]    way_q;
    logic [WSEL_W-1:0]   beat_q;
    logic                rsp_q;
    logic [DATA_W-1:0]   rdat_q;

    addr_t               in_a;
    logic                acc;
    logic                any_hit;
    logic [WAY_W-1:0]    hit_way;
    logic [WAY_W-1:0]    victim;
    logic                last_beat;

    assign in_a      = addr_t'(req_addr);
    assign acc       = req_valid && (state_q == ST_IDLE);
    assign any_hit   = |way_hit;
    assign hit_way   = way_hit[1] ? WAY_W'(1) : WAY_W'(0);
    assign victim    = !way_valid[0] ? WAY_W'(0) :
                       (!way_valid[1] ? WAY_W'(1) : lru_way);
    assign last_beat = mem_rvalid && (beat_q == WSEL_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rsp_q   <= 1'b0;
            beat_q  <= '0;
        end else begin
            rsp_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (acc) begin
                    if (req_write) begin
                        state_q <= ST_WRITE;
                    end else if (any_hit) begin
                        rsp_q <= 1'b1;
                    end else begin
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    state_q <= ST_RD_DATA;
                    beat_q  <= '0;
                end
                ST_RD_DATA: if (mem_rvalid) begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        rsp_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_WRITE: if (mem_wr_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (acc) begin
            sav_q  <= in_a;
            wdat_q <= req_wdata;
            way_q  <= victim;
            if (!req_write && any_hit) rdat_q <= way_rdata[hit_way];
        end
        if (state_q == ST_RD_DATA && mem_rvalid && beat_q == sav_q.word) begin
            rdat_q <= mem_rdata;
        end
    end

    // Data array write: a store hit at acceptance, or a fill beat.
    always_comb begin
        dwr_en   = 1'b0;
        dwr_way  = way_q;
        dwr_idx  = sav_q.idx;
        dwr_word = beat_q;
        dwr_data = mem_rdata;
        if (acc && req_write && any_hit) begin
            dwr_en   = 1'b1;
            dwr_way  = hit_way;
            dwr_idx  = in_a.idx;
            dwr_word = in_a.word;
            dwr_data = req_wdata;
        end else if (state_q == ST_RD_DATA && mem_rvalid) begin
            dwr_en = 1'b1;
        end
    end

    // Recency update on load hit and on fill completion.
    always_comb begin
        fill_en   = (state_q == ST_RD_DATA) && last_beat;
        touch_en  = fill_en || (acc && !req_write && any_hit);
        touch_idx = fill_en ? sav_q.idx : in_a.idx;
        touch_way = fill_en ? way_q : hit_way;
    end

    assign sav_idx     = sav_q.idx;
    assign sav_tag     = sav_q.tag;
    assign sav_way     = way_q;
    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = rsp_q;
    assign rsp_rdata   = rdat_q;
    assign mem_rd_req  = (state_q == ST_RD_REQ);
    assign mem_rd_addr = line_base(sav_q);
    assign mem_wr_req  = (state_q == ST_WRITE);
    assign mem_wr_addr = word_addr(sav_q);
    assign mem_wr_data = wdat_q;

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (req_addr[BYTE_W-1:0] == '0));
    p_hit_next_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && |way_hit) |=> (rsp_valid && !mem_rd_req));
    p_miss_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write && !(|way_hit)) |=> (mem_rd_req && !req_ready));
    p_store_writes_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (mem_wr_req && !req_ready && !rsp_valid));
    p_wr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    p_store_no_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> !mem_rd_req);
    p_busy_in_fill_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> (!req_ready && !rsp_valid));
endmodule

// File: rtl/wtc_cache_top.sv
module wtc_cache_top
    import cache_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_rd_req,
    output logic [WADDR_W-1:0]  mem_rd_addr,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mem_wr_req,
    output logic [WADDR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    input  logic                mem_wr_ack
);
    addr_t                            in_a;
    logic [NUM_WAYS-1:0]              way_hit;
    logic [NUM_WAYS-1:0]              way_valid;
    logic [WAY_W-1:0]                 lru_way;
    logic [NUM_WAYS-1:0][DATA_W-1:0]  way_rdata;
    logic                             fill_en, touch_en, dwr_en;
    logic [IDX_W-1:0]                 touch_idx, dwr_idx, sav_idx;
    logic [WAY_W-1:0]                 touch_way, dwr_way, sav_way;
    logic [WSEL_W-1:0]                dwr_word;
    logic [DATA_W-1:0]                dwr_data;
    logic [TAG_W-1:0]                 sav_tag;

    assign in_a = addr_t'(req_addr);

    wtc_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (in_a.idx),
        .lk_tag    (in_a.tag),
        .way_hit   (way_hit),
        .way_valid (way_valid),
        .lru_way   (lru_way),
        .fill_en   (fill_en),
        .fill_idx  (sav_idx),
        .fill_way  (sav_way),
        .fill_tag  (sav_tag),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way)
    );

    wtc_data_store u_data (
        .clk     (clk),
        .rd_idx  (in_a.idx),
        .rd_word (in_a.word),
        .rd_data (way_rdata),
        .wr_en   (dwr_en),
        .wr_way  (dwr_way),
        .wr_idx  (dwr_idx),
        .wr_word (dwr_word),
        .wr_data (dwr_data)
    );

    wtc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .mem_wr_req  (mem_wr_req),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_ack  (mem_wr_ack),
        .way_hit     (way_hit),
        .way_valid   (way_valid),
        .lru_way     (lru_way),
        .way_rdata   (way_rdata),
        .fill_en     (fill_en),
        .touch_en    (touch_en),
        .touch_idx   (touch_idx),
        .touch_way   (touch_way),
        .dwr_en      (dwr_en),
        .dwr_way     (dwr_way),
        .dwr_idx     (dwr_idx),
        .dwr_word    (dwr_word),
        .dwr_data    (dwr_data),
        .sav_idx     (sav_idx),
        .sav_tag     (sav_tag),
        .sav_way     (sav_way)
    );
endmodule

// File: tb/sim_wtc_cache_top.sv
`timescale 1ns/1ps
module sim_wtc_cache_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_rd_req, mem_wr_req;
    logic [29:0] mem_rd_addr, mem_wr_addr;
    logic        mem_rvalid = 1'b0, mem_wr_ack = 1'b0;
    logic [31:0] mem_rdata = '0, mem_wr_data;

    int vecs = 0, fails = 0;
    int rd_pulses = 0, wr_pulses = 0, rsp_seen = 0;
    logic [29:0] last_rd = '0, last_wr = '0;
    logic [31:0] last_wd = '0;
    logic [31:0] memq [logic [29:0]];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    wtc_cache_top u0 (.*);

    function automatic logic [31:0] mval(logic [29:0] w);
        if (memq.exists(w)) return memq[w];
        return {2'b10, w} ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Memory model: line reads and word writes.
    initial forever begin
        @(negedge clk);
        if (mem_rd_req) begin
            rd_pulses++;
            last_rd = mem_rd_addr;
            repeat (2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mval(last_rd + 30'(i));
                @(negedge clk);
            end
            mem_rvalid = 1'b0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (mem_wr_req) begin
            @(negedge clk);
            mem_wr_ack = 1'b1;
            memq[mem_wr_addr] = mem_wr_data;
            last_wr = mem_wr_addr;
            last_wd = mem_wr_data;
            wr_pulses++;
            @(negedge clk);
            mem_wr_ack = 1'b0;
        end
    end

    // Monitor: pops expected load data as responses appear.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R5 unexpected response", rsp_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rsp_rdata == e, t, rsp_rdata, e);
            end
            rsp_seen++;
        end
    end

    task automatic issue(logic [31:0] a, bit wr, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic load(logic [31:0] a, bit miss, string rq);
        int rd0 = rd_pulses;
        int tgt = rsp_seen + 1;
        exp_q.push_back(mval(a[31:2]));
        tag_q.push_back({rq, " data"});
        issue(a, 1'b0, 32'h0);
        @(negedge clk);
        if (miss) chk(req_ready == 1'b0, "R11 ready low in fill", 32'(req_ready), 32'h0);
        else      chk(rsp_valid == 1'b1, "R3 hit answers next cycle", 32'(rsp_valid), 32'h1);
        wait (rsp_seen >= tgt);
        @(negedge clk);
        chk((rd_pulses - rd0) == int'(miss), {rq, " line reads"}, 32'(rd_pulses - rd0), 32'(miss));
        if (miss) chk(last_rd == {a[31:5], 3'b000}, "R4 line address", 32'(last_rd), 32'({a[31:5], 3'b000}));
    endtask

    task automatic store(logic [31:0] a, logic [31:0] d, string rq);
        int wr0 = wr_pulses, rd0 = rd_pulses, rs0 = rsp_seen;
        issue(a, 1'b1, d);
        @(negedge clk);
        chk(req_ready == 1'b0, "R5 ready low until ack", 32'(req_ready), 32'h0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(wr_pulses == wr0 + 1, {rq, " R5 write count"}, 32'(wr_pulses - wr0), 32'h1);
        chk(last_wr == a[31:2], "R5 write address", 32'(last_wr), 32'(a[31:2]));
        chk(last_wd == d, "R5 write data", last_wd, d);
        chk(rd_pulses == rd0 && rsp_seen == rs0, "R6 store makes no read or response",
            32'(rd_pulses - rd0), 32'h0);
    endtask

    localparam logic [31:0] LA = 32'h0000_1040;
    localparam logic [31:0] LB = 32'h0000_2040;
    localparam logic [31:0] LC = 32'h0000_3040;
    localparam logic [31:0] LD = 32'h0000_5080;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
        chk(mem_rd_req == 1'b0 && mem_wr_req == 1'b0, "R1 memory idle",
            32'({mem_rd_req, mem_wr_req}), 32'h0);

        load(LA + 32'h1C, 1'b1, "R1 R4 R10 cold load A");
        load(LA + 32'h04, 1'b0, "R2 R3 same line hit");
        load(LB, 1'b1, "R8 R10 second way fill B");
        for (int i = 0; i < 2; i++) begin
            load(LA, 1'b0, "R8 alternate A hit");
            load(LB + 32'h08, 1'b0, "R8 alternate B hit");
        end
        load(LA, 1'b0, "R9 touch A");
        store(LB + 32'h08, 32'hCAFE_0001, "R7 store hit B");
        load(LB + 32'h08, 1'b0, "R7 reload stored word");
        load(LA, 1'b0, "R9 touch A again");
        load(LC, 1'b1, "R9 C evicts B");
        load(LA, 1'b0, "R9 A survives");
        load(LB + 32'h08, 1'b1, "R9 B refetched");
        load(LA + 32'h10, 1'b0, "R9 A still resident");
        load(LC, 1'b1, "R9 C was evicted");
        store(LD + 32'h0C, 32'h0BAD_F00D, "R6 store miss D");
        load(LD + 32'h0C, 1'b1, "R6 load after store miss");
        load(LD + 32'h10, 1'b0, "R6 R2 adjacent after fill");
        load(32'h0000_1840, 1'b1, "R2 other set index");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule